// File: doc/BRIEF.md
# Reference Clock Presence Monitor

This block decides whether a slow timing reference (nominally 8 kHz) is arriving. It runs on a fast local clock, nominally 17.664 MHz, which is 2208 times the reference rate. The asynchronous reference passes through a synchronizer and a rising-edge detector. A free-running window timer divides time into observation windows three reference periods long, which is 6624 local cycles by default. The block counts the rising edges seen in each window and judges the reference when the window closes.

The judgement sits in a two-state machine. `ST_LOST` is the reset state and moves to `ST_PRESENT` when a window closes with at least two rising edges. `ST_PRESENT` moves back to `ST_LOST` when a window closes with zero or one rising edge. In every other cycle each state holds. The state drives a present flag and a source select for the loop. The select picks the local crystal while the reference is judged lost, and picks the reference while it is judged present. A one-cycle pulse marks every change of state, so downstream logging or interrupt logic can record it.

Top module: `refclk_presence_monitor`

## Requirements
- R1: While reset is asserted and directly after it, `ref_present` is 0, `use_local` is 1 and `status_chg` is 0 (state `ST_LOST`).
- R2: `ref_in` is synchronized by two flops before edge detection. Only low-to-high transitions are counted, so a level held high for several cycles counts as one edge.
- R3: A window lasts `WINDOW_REFS`×`LOCAL_PER_REF` local cycles, counted from the first clock edge after reset. Status and select change only in the cycle after a window's last cycle.
- R4: A window that closes with 0 or 1 rising edges leaves the block in, or moves it to, `ST_LOST`.
- R5: A window that closes with 2 or 3 rising edges leaves the block in, or moves it to, `ST_PRESENT`.
- R6: The edge count saturates at `WINDOW_REFS` and does not wrap. A window with 4 or more edges is judged present.
- R7: `use_local` is 1 (local crystal selected) exactly while the state is `ST_LOST`, and 0 (reference selected) while the state is `ST_PRESENT`.
- R8: `status_chg` is high for exactly one cycle, the first cycle of the new state, on each transition. It stays low at all other times.
- R9: Every window is judged on its own count. The edge count restarts at zero for each window, so the status can move back and forth on consecutive windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock derived from the crystal |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Asynchronous reference clock input |
| ref_present | output | 1 | 1 while the reference is judged present |
| use_local | output | 1 | Source select: 1 = local crystal, 0 = reference |
| status_chg | output | 1 | One-cycle pulse on each change of status |

## Verification
The assertions assume that `ref_in` is a clean level signal whose high and low phases each last at least two local cycles. Under that assumption the detector never reports edges on back-to-back cycles, and the per-window count only grows until the window is cleared. The bench builds a small configuration with a 24-cycle window. It drives `ref_in` on the falling clock edge with pulses two cycles high and two cycles low. Every pulse sits well inside a window, so no edge is split across a window boundary. It sweeps the per-window edge count from 0 through 5 in an order that exercises both transitions and both holds.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    typedef enum logic [0:0] {
        ST_LOST    = 1'b0,
        ST_PRESENT = 1'b1
    } mon_state_e;
endpackage

// File: rtl/rpm_sync_edge.sv
module rpm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sh_q[STAGES-1];
    end

    assign rise = sh_q[STAGES-1] & ~last_q;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rpm_window_timer.sv
module rpm_window_timer #(
    parameter int WIN = 6624
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [W-1:0] LAST = W'(WIN - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R3
    window_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/rpm_edge_counter.sv
module rpm_edge_counter #(
    parameter int MAXC = 3,
    localparam int W = $clog2(MAXC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] total
);
    localparam logic [W-1:0] CAP = W'(MAXC);

    logic [W-1:0] cnt_q;

    assign total = (cnt_q == CAP) ? cnt_q : cnt_q + W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= total;
    end

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/refclk_presence_monitor.sv
module refclk_presence_monitor #(
    parameter int LOCAL_PER_REF = 2208,
    parameter int WINDOW_REFS   = 3,
    parameter int PRESENT_MIN   = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_present,
    output logic use_local,
    output logic status_chg
);
    import rpm_pkg::*;

    localparam int WIN = LOCAL_PER_REF * WINDOW_REFS;
    localparam int CW  = $clog2(WINDOW_REFS + 1);
    localparam logic [CW-1:0] MIN_C = CW'(PRESENT_MIN);

    logic          edge_seen;
    logic          win_end;
    logic [CW-1:0] win_total;
    mon_state_e    st_q, st_nx;
    logic          chg_q;

    rpm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise(edge_seen)
    );

    rpm_window_timer #(.WIN(WIN)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(win_end)
    );

    rpm_edge_counter #(.MAXC(WINDOW_REFS)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(edge_seen), .clr(win_end),
        .total(win_total)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_LOST:    if (win_end && (win_total >= MIN_C)) st_nx = ST_PRESENT;
            ST_PRESENT: if (win_end && (win_total <  MIN_C)) st_nx = ST_LOST;
            default:    st_nx = ST_LOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOST;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= (st_nx != st_q);
    end

    assign ref_present = (st_q == ST_PRESENT);
    assign use_local   = (st_q == ST_LOST);
    assign status_chg  = chg_q;

    // R3
    select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(use_local));
    // R8
    chg_marks_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |-> (ref_present != $past(ref_present)));
    // R8
    chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |=> !status_chg);
    // R7
    select_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({ref_present, use_local}));
endmodule

// File: tb/sim_refclk_presence_monitor.sv
module sim_refclk_presence_monitor;
    localparam int LPR = 8;
    localparam int NW  = 3;
    localparam int WIN = LPR * NW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic ref_present, use_local, status_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    refclk_presence_monitor #(.LOCAL_PER_REF(LPR), .WINDOW_REFS(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .ref_present(ref_present), .use_local(use_local),
        .status_chg(status_chg)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int pattern [0:15] = '{0, 2, 1, 3, 3, 0, 4, 1, 5, 2, 0, 1, 2, 5, 0, 0};
        bit exp_pres;
        bit prev_pres;
        int n;

        // R1 during reset
        repeat (3) @(negedge clk);
        check("R1 present in reset", ref_present, 1'b0);
        check("R1 select in reset", use_local, 1'b1);
        check("R1 chg in reset", status_chg, 1'b0);
        rst_n = 1'b1;
        exp_pres = 1'b0;
        prev_pres = 1'b0;
        for (int w = 0; w < 16; w++) begin
            n = pattern[w];
            for (int o = 0; o < WIN; o++) begin
                if (o == 0) begin
                    // state judged at the end of the previous window
                    check((w == 0) ? "R1 present after reset" : "R4/R5/R6/R9 status",
                          ref_present, exp_pres);
                    check("R7 select", use_local, !exp_pres);
                    check("R8 change pulse", status_chg, (exp_pres != prev_pres));
                end else begin
                    check("R3 status holds mid-window", ref_present, exp_pres);
                    check("R8 no pulse mid-window", status_chg, 1'b0);
                end
                // pulses: high at offsets 2+4k and 3+4k, k < n (R2: one edge each)
                ref_in = (o >= 2) && (((o - 2) / 4) < n) && (((o - 2) % 4) < 2);
                @(negedge clk);
            end
            prev_pres = exp_pres;
            exp_pres  = (n >= 2);
        end
        check("R9 final status", ref_present, exp_pres);
        check("R8 final pulse", status_chg, (exp_pres != prev_pres));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule